// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Controller

This block is the transmit half of a serial channel. It sends one byte at a time in either of two modes. In asynchronous mode, a 4-bit prescaler counts a base-clock enable. That base clock is shared with the channel's receive side. The prescaler yields one bit-rate tick per sixteen base clocks, and each tick carries one bit of a ten-bit frame out on TXD. In clock-synchronous mode, the byte shifts out least significant bit first against a shift clock. That shift clock is either generated here and driven on SCLK, or taken from an outside SCLK pin through a synchronizer.

Software-side logic writes a byte with a one-cycle strobe and watches `busy`. The mode inputs and the edge-select input must be held steady while `busy` is high. Dropping `chan_en` stops the channel at once and returns every output to its idle level.

Top module: `dual_serial_tx`

## Requirements
- R1: While `chan_en` is high, the prescaler yields one tick on every 16th clock that has `base_en` high. While `chan_en` is low, the prescaler is cleared, so the first tick after enabling comes on the 16th such clock.
- R2: In asynchronous mode (`mode_io`=0), TXD idles high. A frame does not start at the write but at the next tick. It is then a low start bit, the eight data bits least significant first, and a high stop bit, each lasting one tick period.
- R3: `busy` rises on the clock edge that accepts a write. In asynchronous mode it falls at the tick that ends the stop bit, and no further frame follows.
- R4: A write is ignored while `busy` is high: the frame in flight keeps its data and ends at its normal time. A write is also ignored while `chan_en` is low: `busy` stays low and no frame goes out.
- R5: With `mode_io`=1 and `clk_ext`=0, `sclk_oe` is 1 and SCLK idles high. SCLK changes level on each `base_en` clock after a write, starting with a falling edge. Bit k appears on TXD at the (k+1)th falling edge and holds through the following rising edge. After the 8th rising edge, `busy` falls and TXD returns high. Exactly eight pulses are produced.
- R6: With `mode_io`=1 and `clk_ext`=1, `sclk_oe` is 0. Data changes on the rising edges of `sclk_in` when `edge_rise`=1, and on the falling edges when it is 0. Bit k appears at the (k+1)th selected edge, and the 9th selected edge ends the transfer (`busy` low, TXD high). The opposite edges have no effect.
- R7: A change on `sclk_in` passes through two synchronizing flops and an edge detector. The TXD update it causes happens at the third rising `clk` edge after the change.
- R8: Driving `chan_en` low ends any transfer. On the next clock, `busy` is 0, TXD is 1 and SCLK is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Channel enable; low clears prescaler and aborts |
| base_en | input | 1 | Serial base-clock enable, shared with the receive side |
| mode_io | input | 1 | 0 asynchronous frame, 1 clock-synchronous shift |
| clk_ext | input | 1 | In synchronous mode: 1 shift clock comes from `sclk_in` |
| edge_rise | input | 1 | With an outside clock: 1 data changes on rising edges, 0 on falling |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | DATA_W | Byte to send |
| busy | output | 1 | High from an accepted write until the last bit ends |
| txd | output | 1 | Serial data out |
| sclk_in | input | 1 | Outside shift clock, asynchronous to `clk` |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Drive enable for the SCLK pad |

## Verification
The hardest situations to reach are the two that depend on where the prescaler stands when a byte arrives. One is the wait for the first tick after a write. The other is a second write landing in the middle of a frame. The ports do not expose the prescaler phase. So the stimulus raises `chan_en` on a known edge, writes on the edge that follows, and counts edges to the expected start. For the mid-frame write, the bench places the extra strobe inside a bit period it has already aligned to the falling start bit. A half-rate `base_en` pattern shows that the tick spacing follows the enable, not the clock.

// File: rtl/sertx_pkg.sv
// Package: shared mode type for the dual-mode serial transmitter.
package sertx_pkg;
    typedef enum logic [1:0] {
        MODE_UART   = 2'd0,
        MODE_IO_INT = 2'd1,
        MODE_IO_EXT = 2'd2
    } tx_mode_e;
endpackage

// File: rtl/sertx_prescale.sv
// Bit-rate prescaler. A PRE_W-bit counter advances on each base-clock enable
// while the channel is on, and pulses tick when it wraps. Assumes base_en is
// a single-cycle qualifier in the clk domain.
module sertx_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic base_en,
    output logic tick
);
    logic [PRE_W-1:0] cnt;

    // Count base clocks; held at zero while the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (base_en)  cnt <= cnt + 1'b1;
    end

    // Tick on the base clock that wraps the counter.
    assign tick = en && base_en && (cnt == '1);

    // R1: a disabled channel leaves the counter cleared.
    a_r1_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
    // R1: ticks never come on back-to-back clocks.
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sertx_edge_sync.sv
// Synchronizer and edge detector for an outside shift clock. STAGES flops
// bring sclk_in into the clk domain; one more flop gives the previous level.
// Assumes sclk_in half-periods are longer than STAGES+1 clk cycles.
module sertx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    // Shift the raw pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], sclk_in};
    end

    // Compare the newest synchronized level with the one before it.
    assign rise =  chain[STAGES-1] && !chain[STAGES];
    assign fall = !chain[STAGES-1] &&  chain[STAGES];

    // R7: one pin transition gives a single detected edge.
    a_r7_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sertx_bitseq.sv
// Transmit sequencer. Holds the written byte and walks a phase counter, one
// step per step pulse, choosing the TXD and SCLK levels for each phase from
// the mode. Assumes mode is stable while busy.
module sertx_bitseq
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  tx_mode_e          mode,
    input  logic              step,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              txd,
    output logic              sclk_int
);
    localparam int PH_W  = $clog2(2 * DATA_W + 1);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [PH_W-1:0] END_UART = PH_W'(DATA_W + 3);
    localparam logic [PH_W-1:0] END_INT  = PH_W'(2 * DATA_W);
    localparam logic [PH_W-1:0] END_EXT  = PH_W'(DATA_W + 1);

    logic [DATA_W-1:0] hold;
    logic [PH_W-1:0]   phase, ph_nx;
    logic [IDX_W-1:0]  idx;
    logic              nx_txd, nx_sclk, last;

    // Decide the levels for the next phase and whether it ends the transfer.
    always_comb begin
        ph_nx   = phase + PH_W'(1);
        nx_txd  = txd;
        nx_sclk = 1'b1;
        idx     = '0;
        last    = 1'b0;
        unique case (mode)
            MODE_UART: begin
                last = (ph_nx == END_UART);
                idx  = IDX_W'(ph_nx - PH_W'(2));
                if (ph_nx == PH_W'(1))                nx_txd = 1'b0;
                else if (ph_nx <= PH_W'(DATA_W + 1))  nx_txd = hold[idx];
                else                                  nx_txd = 1'b1;
            end
            MODE_IO_INT: begin
                last    = (ph_nx == END_INT);
                idx     = IDX_W'((ph_nx - PH_W'(1)) >> 1);
                nx_sclk = ~ph_nx[0];
                if (ph_nx[0]) nx_txd = hold[idx];
            end
            MODE_IO_EXT: begin
                last   = (ph_nx == END_EXT);
                idx    = IDX_W'(ph_nx - PH_W'(1));
                nx_txd = hold[idx];
            end
            default: ;
        endcase
    end

    // Accept a byte when idle, then advance one phase per step.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy     <= 1'b0;
            phase    <= '0;
            txd      <= 1'b1;
            sclk_int <= 1'b1;
            if (!rst_n) hold <= '0;
        end else if (!busy) begin
            if (wr_stb) begin
                busy  <= 1'b1;
                hold  <= wr_data;
                phase <= '0;
            end
        end else if (step) begin
            if (last) begin
                busy     <= 1'b0;
                phase    <= '0;
                txd      <= 1'b1;
                sclk_int <= 1'b1;
            end else begin
                phase    <= ph_nx;
                txd      <= nx_txd;
                sclk_int <= nx_sclk;
            end
        end
    end

    // R2: idle lines sit high.
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && sclk_int));
    // R3: without a step the line and the busy flag hold.
    a_r3_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en && !step) |=> ($stable(txd) && busy));
    // R4: a write during a transfer leaves the held byte alone.
    a_r4_ignore_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb) |=> $stable(hold));
    // R8: disabling the channel returns it to idle on the next clock.
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && txd && sclk_int));
    // R5: with the generated clock, data moves only while SCLK is low.
    a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == MODE_IO_INT && !$stable(txd)) |-> !sclk_int);
endmodule

// File: rtl/dual_serial_tx.sv
// Top of the dual-mode serial transmitter. Decodes the mode pins, selects
// the step source (prescaler tick, base clock or synchronized outside
// edge) and drives the SCLK pad enable. Assumes the mode pins are steady
// while busy.
module dual_serial_tx
    import sertx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PRE_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              base_en,
    input  logic              mode_io,
    input  logic              clk_ext,
    input  logic              edge_rise,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              txd,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe
);
    tx_mode_e mode;
    logic     tick, ext_rise, ext_fall, step;

    // Map the mode pins onto the internal mode type.
    always_comb begin
        if (!mode_io)     mode = MODE_UART;
        else if (clk_ext) mode = MODE_IO_EXT;
        else              mode = MODE_IO_INT;
    end

    sertx_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .base_en(base_en), .tick(tick)
    );

    sertx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
        .rise(ext_rise), .fall(ext_fall)
    );

    // Pick the event that advances the sequencer in each mode.
    always_comb begin
        unique case (mode)
            MODE_UART:   step = tick;
            MODE_IO_INT: step = base_en;
            MODE_IO_EXT: step = edge_rise ? ext_rise : ext_fall;
            default:     step = 1'b0;
        endcase
    end

    sertx_bitseq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .mode(mode), .step(step),
        .wr_stb(wr_stb), .wr_data(wr_data), .busy(busy), .txd(txd),
        .sclk_int(sclk_out)
    );

    // The pad is driven only when this block makes the shift clock.
    assign sclk_oe = (mode == MODE_IO_INT);
endmodule

// File: tb/sim_dual_serial_tx.sv
`timescale 1ns/1ps
module sim_dual_serial_tx;
    logic       clk = 1'b0, rst_n = 1'b0, chan_en = 1'b0, base_en = 1'b1;
    logic       mode_io = 1'b0, clk_ext = 1'b0, edge_rise = 1'b0;
    logic       wr_stb = 1'b0, sclk_in = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       busy, txd, sclk_out, sclk_oe;
    int         n_chk = 0, n_fail = 0;
    bit         half_rate = 0, done = 0;

    // Vector layout: {mode_io, clk_ext, edge_rise, data[7:0]}
    localparam logic [10:0] VECS [7] = '{11'h0A5, 11'h000, 11'h0FF, 11'h43C,
                                         11'h481, 11'h796, 11'h65A};

    dual_serial_tx u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .base_en(base_en),
        .mode_io(mode_io), .clk_ext(clk_ext), .edge_rise(edge_rise),
        .wr_stb(wr_stb), .wr_data(wr_data), .busy(busy), .txd(txd),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe)
    );

    initial forever #4 clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            if (half_rate) base_en = ~base_en;
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_data = d; wr_stb = 1'b1;
        cyc(1);
        wr_stb = 1'b0;
    endtask

    task automatic wait_idle(input int lim);
        int w = 0;
        while (busy && w < lim) begin cyc(1); w++; end
    endtask

    // Asynchronous frame; inj places an extra write inside data bit 3.
    task automatic run_uart(input logic [7:0] d, input bit inj, output logic [7:0] got);
        int w = 0;
        do_write(d);
        while (txd && w < 40) begin cyc(1); w++; end
        cyc(8);
        chk("R2 start bit low", txd, 0);
        for (int i = 0; i < 8; i++) begin
            if (inj && i == 3) begin cyc(15); do_write(8'h00); end
            else cyc(16);
            got[i] = txd;
        end
        cyc(16);
        chk("R2 stop bit high", txd, 1);
        chk("R3 busy during stop", busy, 1);
        cyc(8);
        chk("R3 busy clears after stop", busy, 0);
    endtask

    task automatic run_int(input logic [7:0] d, output logic [7:0] got);
        bit ok = 1;
        chk("R5 pad enable", sclk_oe, 1);
        chk("R5 idle SCLK high", sclk_out, 1);
        do_write(d);
        for (int k = 0; k < 8; k++) begin
            cyc(1);
            if (sclk_out != 1'b0) ok = 0;
            got[k] = txd;
            cyc(1);
            if (sclk_out != 1'b1) ok = 0;
            if (k < 7 && txd != got[k]) ok = 0;
        end
        chk("R5 pulse shape and hold", ok, 1);
        chk("R5 busy clears at 8th rise", busy, 0);
        chk("R5 txd idle after byte", txd, 1);
        cyc(5);
        chk("R5 no ninth pulse", sclk_out, 1);
    endtask

    task automatic run_ext(input logic [7:0] d, input bit rise, output logic [7:0] got);
        bit   ok = 1;
        logic idle = rise ? 1'b0 : 1'b1;
        sclk_in = idle;
        cyc(4);
        chk("R6 pad released", sclk_oe, 0);
        do_write(d);
        for (int k = 0; k < 9; k++) begin
            sclk_in = ~idle;
            cyc(4);
            if (k < 8) begin
                got[k] = txd;
                if (!busy) ok = 0;
            end
            sclk_in = idle;
            cyc(4);
            if (k < 8 && txd != got[k]) ok = 0;
        end
        chk("R6 opposite edge no effect", ok, 1);
        chk("R6 busy clears at 9th edge", busy, 0);
        chk("R6 txd idle after byte", txd, 1);
    endtask

    initial begin
        logic [7:0] got;
        int         w;
        cyc(3);
        // reset state, R2 and R5 idle levels
        chk("R2 reset txd", txd, 1);
        chk("R3 reset busy", busy, 0);
        chk("R5 reset sclk", sclk_out, 1);
        chk("R5 reset pad enable", sclk_oe, 0);
        rst_n = 1'b1;
        cyc(2);

        // R1/R2: first tick comes on the 16th base clock after enable
        chan_en = 1'b1;
        do_write(8'h0F);
        chk("R3 busy after write", busy, 1);
        cyc(14);
        chk("R2 no start before first tick", txd, 1);
        cyc(1);
        chk("R1 start at 16th base clock", txd, 0);
        wait_idle(300);

        // Vector table across all modes
        for (int v = 0; v < 7; v++) begin
            mode_io = VECS[v][10]; clk_ext = VECS[v][9]; edge_rise = VECS[v][8];
            cyc(2);
            got = 8'h00;
            if (!mode_io)     run_uart(VECS[v][7:0], 0, got);
            else if (!clk_ext) run_int(VECS[v][7:0], got);
            else              run_ext(VECS[v][7:0], edge_rise, got);
            chk("R2/R5/R6 data LSB first", int'(got), int'(VECS[v][7:0]));
        end
        mode_io = 1'b0; clk_ext = 1'b0;
        cyc(2);

        // R1: half-rate base clock doubles the bit period
        half_rate = 1;
        do_write(8'h01);
        w = 0;
        while (txd && w < 80) begin cyc(1); w++; end
        w = 0;
        while (!txd && w < 80) begin cyc(1); w++; end
        chk("R1 bit period with half-rate base", w, 32);
        wait_idle(400);
        half_rate = 0; base_en = 1'b1;
        cyc(2);

        // R4: write during a frame is ignored
        run_uart(8'hA5, 1, got);
        chk("R4 frame data kept", int'(got), 8'hA5);
        cyc(40);
        chk("R4 no second frame", txd, 1);
        chk("R3 stays idle", busy, 0);

        // R4: write while disabled is ignored
        chan_en = 1'b0;
        do_write(8'h00);
        chk("R4 disabled write busy", busy, 0);
        chan_en = 1'b1;
        cyc(40);
        chk("R4 disabled write no frame", txd, 1);

        // R8: abort an asynchronous frame
        do_write(8'h00);
        w = 0;
        while (txd && w < 40) begin cyc(1); w++; end
        cyc(3);
        chan_en = 1'b0;
        cyc(1);
        chk("R8 abort busy", busy, 0);
        chk("R8 abort txd", txd, 1);
        chan_en = 1'b1;

        // R8: abort with SCLK low
        mode_io = 1'b1; clk_ext = 1'b0;
        cyc(2);
        do_write(8'h00);
        cyc(1);
        chk("R5 first edge falls", sclk_out, 0);
        chan_en = 1'b0;
        cyc(1);
        chk("R8 abort sclk", sclk_out, 1);
        chk("R8 abort busy io", busy, 0);
        chan_en = 1'b1;

        // R7: synchronizer latency, rising edges, bit0 = 0
        clk_ext = 1'b1; edge_rise = 1'b1; sclk_in = 1'b0;
        cyc(4);
        do_write(8'h96);
        sclk_in = 1'b1;
        cyc(2);
        chk("R7 no change after two edges", txd, 1);
        cyc(1);
        chk("R7 change at third edge", txd, 0);
        for (int k = 0; k < 8; k++) begin
            sclk_in = 1'b0; cyc(4);
            sclk_in = 1'b1; cyc(4);
        end
        chk("R7 transfer complete", busy, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule